// File: doc/BRIEF.md
# Audio System Clock Generator with Master/Slave Direction Control

This block produces the three clocks of a serial audio link from one core clock, or hands those clocks over to an external source. The core clock runs at 512 times the frame rate, which is twice the master-clock rate; it comes from a PLL or oscillator outside this block. When the role input selects master, the block divides the core clock down to a master clock at 256×Fs, a bit clock at 64×Fs and a frame clock at Fs. It drives all three out and enables the bit and frame clock pads. When the role input selects slave, the pad enables drop and the bit and frame clocks come in from outside. Those inputs must be synchronous to the master clock, but they may have any phase. The master clock output stays low in slave mode.

The dividers form one chain: the master clock toggles on every core cycle, and the bit clock toggles on every second falling master-clock edge. The frame clock toggles on every 32nd falling bit-clock edge, so it only ever changes together with a bit-clock fall. Reset clears the whole chain. So does the slave role. When reset is released, or when the role returns to master, every clock starts from a known phase. A double-speed input is recorded in a register, so the rest of the chip can tell whether Fs is 88.2/96 kHz or one of the normal rates.

Top module: `acg_clkgen`

## Requirements
- R1: While `rst_n` is low at a rising core edge, `mclk_out`, `bclk_out`, `fclk_out` and `rate_x2` are 0 after that edge.
- R2: In master role (`master_sel` = 1) and out of reset, `mclk_out` inverts at every rising core edge, giving a period of 2 core cycles.
- R3: In master role, `bclk_out` has a period of 2×MCLK_DIV core cycles (8 by default) with equal high and low times, and it changes only at edges where `mclk_out` goes low.
- R4: In master role, `fclk_out` has a period of MCLK_DIV×BCLK_PER_FRAME×2 core cycles (512 by default) with equal halves, and it changes only at edges where `bclk_out` falls.
- R5: After reset is released with `master_sel` = 1, `mclk_out` is 1 after the first edge, `bclk_out` first rises after MCLK_DIV edges, and `fclk_out` first rises after MCLK_DIV×BCLK_PER_FRAME edges (256 by default).
- R6: From the first rising edge at which `master_sel` is 0, `mclk_out`, `bclk_out` and `fclk_out` are 0. They stay 0 while the role stays slave.
- R7: `bclk_oe` and `fclk_oe` equal `master_sel` at all times: 1 drives the pad, 0 releases it.
- R8: `bclk_int` and `fclk_int` carry the generated clocks in master role, and carry `bclk_in` and `fclk_in` in slave role.
- R9: When `master_sel` returns from 0 to 1, the clocks restart with the same phase sequence as after reset release (R5).
- R10: `rate_x2` equals the value `dbl_speed` had at the previous rising core edge (1 = doubled frame rate, 0 = normal rate).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_core | input | 1 | Core clock at 512×Fs |
| rst_n | input | 1 | Synchronous reset, active low |
| master_sel | input | 1 | Role: 1 = generate clocks, 0 = accept external clocks |
| dbl_speed | input | 1 | 1 when the frame rate is doubled |
| bclk_in | input | 1 | Bit clock from the pad in slave role |
| fclk_in | input | 1 | Frame clock from the pad in slave role |
| mclk_out | output | 1 | Master clock output, 256×Fs, low in slave role |
| bclk_out | output | 1 | Generated bit clock to the pad, 64×Fs |
| bclk_oe | output | 1 | Bit clock pad output enable |
| fclk_out | output | 1 | Generated frame clock to the pad, Fs |
| fclk_oe | output | 1 | Frame clock pad output enable |
| bclk_int | output | 1 | Bit clock for internal use, from either source |
| fclk_int | output | 1 | Frame clock for internal use, from either source |
| rate_x2 | output | 1 | Registered double-speed flag |

## Verification
A divider that counts wrong, or that misses a clear, moves a clock edge. A bad bit-clock counter shows up as a misplaced bit-clock edge within 8 core cycles. A bad frame counter only shows up at the next frame edge, up to 256 cycles later. For that reason, the bench measures the distance from reset release, and from the return to master role, to the first frame-clock rise. It also compares all three clocks against an arithmetic phase model on every cycle. A missing clear in slave role leaves a nonzero clock on the pads one edge after the role change, and a wrong source selection shows up at once on the internal clock outputs while random slave inputs are applied.

// File: rtl/acg_pkg.sv
// Shared definitions for the audio clock generator.
// Assumes a chain of three toggle stages: master, bit and frame clock.
package acg_pkg;

    localparam int STAGES = 3;

    typedef enum int {
        STG_MCLK = 0,
        STG_BCLK = 1,
        STG_FCLK = 2
    } stage_e;

    typedef enum logic {
        ROLE_SLAVE  = 1'b0,
        ROLE_MASTER = 1'b1
    } clk_role_e;

    // Number of input strobes between two toggles of a given stage.
    function automatic int stage_half(int idx, int mclk_div, int bclk_per_frame);
        int h;
        case (idx)
            STG_MCLK: h = 1;
            STG_BCLK: h = mclk_div / 2;
            default:  h = bclk_per_frame / 2;
        endcase
        return h;
    endfunction

endpackage

// File: rtl/acg_div_chain.sv
// Cascaded toggle dividers. Stage 0 toggles on every core cycle.
// Each later stage counts the falling toggles of the stage before it.
// Assumes MCLK_DIV and BCLK_PER_FRAME are even and at least 2.
// A synchronous clear returns every stage to zero phase.
module acg_div_chain #(
    parameter int MCLK_DIV       = 4,
    parameter int BCLK_PER_FRAME = 64
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    output logic [acg_pkg::STAGES-1:0] lvl
);
    import acg_pkg::*;

    localparam int BCLK_HALF  = MCLK_DIV / 2;
    localparam int FRAME_HALF = BCLK_PER_FRAME / 2;
    localparam int MAX_HALF   = (FRAME_HALF > BCLK_HALF) ? FRAME_HALF : BCLK_HALF;
    localparam int CW         = $clog2(MAX_HALF) + 1;

    logic [STAGES-1:0] stb;

    assign stb[0] = 1'b1;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        localparam int HALF = stage_half(i, MCLK_DIV, BCLK_PER_FRAME);

        logic [CW-1:0] cnt;
        logic          q;
        logic          wrap;

        assign wrap = stb[i] && (cnt == CW'(HALF - 1));

        // Count incoming strobes and toggle the level on every HALF-th one.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                cnt <= '0;
                q   <= 1'b0;
            end else if (stb[i]) begin
                if (wrap) begin
                    cnt <= '0;
                    q   <= ~q;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end

        assign lvl[i] = q;

        if (i < STAGES - 1) begin : g_fwd
            assign stb[i+1] = wrap && q;
        end
    end

endmodule

// File: rtl/acg_pad.sv
// Pad direction and internal clock source selection.
// Assumes the generated levels are already forced to zero in slave role.
module acg_pad (
    input  logic                       master_sel,
    input  logic [acg_pkg::STAGES-1:0] lvl,
    input  logic                       bclk_in,
    input  logic                       fclk_in,
    output logic                       mclk_out,
    output logic                       bclk_out,
    output logic                       fclk_out,
    output logic                       bclk_oe,
    output logic                       fclk_oe,
    output logic                       bclk_int,
    output logic                       fclk_int
);
    import acg_pkg::*;

    clk_role_e role;

    assign role = clk_role_e'(master_sel);

    // Drive the pads from the divider levels.
    always_comb begin
        mclk_out = lvl[STG_MCLK];
        bclk_out = lvl[STG_BCLK];
        fclk_out = lvl[STG_FCLK];
    end

    // Enable the pads and pick the internal source according to the role.
    always_comb begin
        bclk_oe  = (role == ROLE_MASTER);
        fclk_oe  = (role == ROLE_MASTER);
        bclk_int = (role == ROLE_MASTER) ? lvl[STG_BCLK] : bclk_in;
        fclk_int = (role == ROLE_MASTER) ? lvl[STG_FCLK] : fclk_in;
    end

endmodule

// File: rtl/acg_clkgen.sv
// Audio clock generator top. It divides a 512xFs core clock into the
// master, bit and frame clocks in master role, and releases the bit and
// frame pads in slave role. Assumes external clocks in slave role are
// synchronous to clk_core. Reset is synchronous and active low.
module acg_clkgen #(
    parameter int MCLK_DIV       = 4,
    parameter int BCLK_PER_FRAME = 64
) (
    input  logic clk_core,
    input  logic rst_n,
    input  logic master_sel,
    input  logic dbl_speed,
    input  logic bclk_in,
    input  logic fclk_in,
    output logic mclk_out,
    output logic bclk_out,
    output logic bclk_oe,
    output logic fclk_out,
    output logic fclk_oe,
    output logic bclk_int,
    output logic fclk_int,
    output logic rate_x2
);
    import acg_pkg::*;

    logic [STAGES-1:0] lvl;
    logic              div_clr;

    assign div_clr = !master_sel;

    acg_div_chain #(
        .MCLK_DIV       (MCLK_DIV),
        .BCLK_PER_FRAME (BCLK_PER_FRAME)
    ) u_div (
        .clk   (clk_core),
        .rst_n (rst_n),
        .clr   (div_clr),
        .lvl   (lvl)
    );

    acg_pad u_pad (
        .master_sel (master_sel),
        .lvl        (lvl),
        .bclk_in    (bclk_in),
        .fclk_in    (fclk_in),
        .mclk_out   (mclk_out),
        .bclk_out   (bclk_out),
        .fclk_out   (fclk_out),
        .bclk_oe    (bclk_oe),
        .fclk_oe    (fclk_oe),
        .bclk_int   (bclk_int),
        .fclk_int   (fclk_int)
    );

    // Record the double-speed setting.
    always_ff @(posedge clk_core) begin
        if (!rst_n) rate_x2 <= 1'b0;
        else        rate_x2 <= dbl_speed;
    end

endmodule

// File: rtl/acg_clkgen_chk.sv
// Timing checks on the clock generator ports, bound into the top module.
module acg_clkgen_chk (
    input logic clk_core,
    input logic rst_n,
    input logic master_sel,
    input logic dbl_speed,
    input logic mclk_out,
    input logic bclk_out,
    input logic fclk_out,
    input logic rate_x2
);

    assert_mclk_toggle_R2: assert property (@(posedge clk_core) disable iff (!rst_n)
        $past(rst_n) && $past(master_sel) |-> mclk_out != $past(mclk_out));

    assert_bclk_on_mclk_fall_R3: assert property (@(posedge clk_core) disable iff (!rst_n)
        $past(rst_n) && $past(master_sel) && !$stable(bclk_out) |-> !mclk_out);

    assert_fclk_on_bclk_fall_R4: assert property (@(posedge clk_core) disable iff (!rst_n)
        $past(rst_n) && $past(master_sel) && !$stable(fclk_out) |-> $fell(bclk_out));

    assert_slave_quiet_R6: assert property (@(posedge clk_core) disable iff (!rst_n)
        $past(rst_n) && !$past(master_sel) |-> !mclk_out && !bclk_out && !fclk_out);

    assert_restart_phase_R9: assert property (@(posedge clk_core) disable iff (!rst_n)
        $past(rst_n) && $past(master_sel) && !$past(master_sel, 2)
        |-> mclk_out && !bclk_out && !fclk_out);

    assert_rate_follow_R10: assert property (@(posedge clk_core) disable iff (!rst_n)
        $past(rst_n) |-> rate_x2 == $past(dbl_speed));

endmodule

bind acg_clkgen acg_clkgen_chk u_chk (
    .clk_core   (clk_core),
    .rst_n      (rst_n),
    .master_sel (master_sel),
    .dbl_speed  (dbl_speed),
    .mclk_out   (mclk_out),
    .bclk_out   (bclk_out),
    .fclk_out   (fclk_out),
    .rate_x2    (rate_x2)
);

// File: tb/acg_clkgen_tb.sv
// Bench for the clock generator: an arithmetic phase model compared on every cycle.
module acg_clkgen_tb;
    localparam int MD   = 4;
    localparam int BPF  = 64;
    localparam int CORE = MD * BPF;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n = 1'b0, master_sel = 1'b1, dbl_speed = 1'b0, bclk_in = 1'b0, fclk_in = 1'b0;
    logic mclk_out, bclk_out, bclk_oe, fclk_out, fclk_oe, bclk_int, fclk_int, rate_x2;

    acg_clkgen #(.MCLK_DIV(MD), .BCLK_PER_FRAME(BPF)) u_dut (
        .clk_core (clk), .rst_n (rst_n), .master_sel (master_sel), .dbl_speed (dbl_speed),
        .bclk_in (bclk_in), .fclk_in (fclk_in), .mclk_out (mclk_out), .bclk_out (bclk_out),
        .bclk_oe (bclk_oe), .fclk_out (fclk_out), .fclk_oe (fclk_oe), .bclk_int (bclk_int),
        .fclk_int (fclk_int), .rate_x2 (rate_x2)
    );

    int checks = 0;
    int errors = 0;
    bit cmp_en = 1'b0;
    int p = 0;
    bit exp_rate = 1'b0;

    // Phase model: core edges since the last reset release or return to master.
    always @(posedge clk) begin
        if (!rst_n || !master_sel) p = 0;
        else                       p = p + 1;
        exp_rate = rst_n ? dbl_speed : 1'b0;
    end

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic chk_int(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison, 1 ns after the falling edge.
    always @(negedge clk) begin
        if (cmp_en) begin
            #1;
            chk(mclk_out, 1'((p % 2) != 0),           "R2/R6 mclk_out");
            chk(bclk_out, 1'(((p / MD) % 2) != 0),    "R3/R6 bclk_out");
            chk(fclk_out, 1'(((p / CORE) % 2) != 0),  "R4/R6 fclk_out");
            chk(bclk_oe, master_sel,                  "R7 bclk_oe");
            chk(fclk_oe, master_sel,                  "R7 fclk_oe");
            chk(bclk_int, master_sel ? 1'(((p / MD) % 2) != 0) : bclk_in,   "R8 bclk_int");
            chk(fclk_int, master_sel ? 1'(((p / CORE) % 2) != 0) : fclk_in, "R8 fclk_int");
            chk(rate_x2, exp_rate,                    "R10 rate_x2");
        end
    end

    task automatic edges_to_frame(output int n);
        n = 0;
        while (fclk_out !== 1'b1 && n < 4 * CORE) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        int n;
        repeat (4) @(negedge clk);
        #1;
        chk(mclk_out, 1'b0, "R1 reset mclk_out");
        chk(bclk_out, 1'b0, "R1 reset bclk_out");
        chk(fclk_out, 1'b0, "R1 reset fclk_out");
        chk(rate_x2,  1'b0, "R1 reset rate_x2");
        @(negedge clk);
        cmp_en = 1'b1;
        rst_n  = 1'b1;
        edges_to_frame(n);
        chk_int(n, CORE, "R5 first frame rise after reset");
        // Master run with the double-speed flag changing.
        for (int i = 0; i < 1500; i++) begin
            @(negedge clk);
            if (i % 37 == 0) dbl_speed = ~dbl_speed;
        end
        // Slave role with random external clocks.
        master_sel = 1'b0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            bclk_in = 1'($urandom_range(0, 1));
            fclk_in = 1'($urandom_range(0, 1));
        end
        // Return to master: same restart as after reset (R9).
        master_sel = 1'b1;
        edges_to_frame(n);
        chk_int(n, CORE, "R9 first frame rise after return to master");
        repeat (600) @(negedge clk);
        // Reset in the middle of a frame (R1, R5).
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        edges_to_frame(n);
        chk_int(n, CORE, "R5 first frame rise after second reset");
        repeat (300) @(negedge clk);
        cmp_en = 1'b0;
        #2;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog.
    initial begin
        #(200000 * 8);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule